// File: doc/BRIEF.md
# Multichannel Pulse Timestamper

This block timestamps pulse arrivals on a set of detector inputs (8 by default, up to 32) relative to a trigger, using a 100 MHz clock. Each detector line is captured on both clock edges so that a pulse as short as 5 ns is still seen. Rising edges are resolved to one 10 ns tick.

Once the block is armed, each rising edge on the trigger input opens an acquisition window. A tick counter runs from zero for as many ticks as the programmed maximum allows. On every tick where one or more detectors show a new rising edge, one 64-bit record is produced. The record holds a bitmask of the channels that fired in that tick, an 8-bit tag sampled from external pins and the tick count. Records leave on a valid/ready stream through a single holding register.

Arming latches a window length and a number of windows. After the last window the block pulses done and stops accepting triggers until it is armed again.

Top module: `pulse_tdc`

## Requirements
- R1: A detector pulse 5 ns wide, lying wholly between two rising clock edges, is recorded.
- R2: Record bits [23:0] hold the tick count. A rise that is d clock periods after the trigger rise (same phase) reads d-1. A rise in the same period as the trigger rise is not recorded.
- R3: Record bits [31:24] carry the synchronized value of the 8-bit tag input.
- R4: Record bits [63:32] hold a mask in which bit 32+i is set when channel i rose in that tick. Rises on several channels in the same tick share one record, and mask bits above the channel count are zero.
- R5: No record is produced on a tick without a new rise, and none is produced outside an open window.
- R6: A window closes after the tick whose count equals the programmed maximum. A rise at count max is recorded and a rise at count max+1 is not.
- R7: A trigger rise while a window is open neither restarts nor changes the count.
- R8: Arming runs exactly the programmed number of windows, one per trigger rise. `done_o` is high for one cycle after the last window closes. Arming with zero windows gives the done pulse with no window.
- R9: Once the block is done, trigger rises and detector pulses produce no record until `arm_i` is asserted again.
- R10: While `m_tvalid_o` is high and `m_tready_i` is low, the valid flag and the record stay unchanged.
- R11: `overflow_o` sets when a record is produced while the holding register is full and stalled. It stays set until the next accepted arm, which clears it.
- R12: After reset, `m_tvalid_o`, `done_o` and `overflow_o` are low.
- R13: Two pulses on one channel 20 ns apart give two separate records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Latch configuration and start a run; honoured only while idle |
| cfg_max_i | input | 24 | Last count of each window, in 10 ns ticks |
| cfg_iter_i | input | ITER_W | Number of windows per run |
| trig_i | input | 1 | Asynchronous trigger; a rising edge opens a window |
| tag_i | input | 8 | Asynchronous external tag placed in each record |
| pulse_i | input | N_CH | Asynchronous detector lines |
| m_tvalid_o | output | 1 | Record valid |
| m_tready_i | input | 1 | Sink ready |
| m_tdata_o | output | 64 | Record: mask, tag, count |
| done_o | output | 1 | One-cycle pulse after the final window |
| overflow_o | output | 1 | Sticky flag for a record lost to back-pressure |

## Verification
The detector lines are driven with single-channel pulses, with coincident pulses on several channels, with a pulse on the trigger tick itself and with same-channel pulses two ticks apart. Together these separate merging into one record from splitting into several, and show where the count starts. Pulses are placed at count max and at max+1, and a second trigger is sent inside an open window. These pin down where a window closes and show that a retrigger is ignored. A two-window run, a zero-window run and a trigger sent after completion check the iteration count and the done pulse. A stalled sink with two records pending shows which record is kept and that the overflow flag holds until the next arm.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int CNT_W  = 24;
  localparam int TAG_W  = 8;
  localparam int MASK_W = 32;
  localparam int WORD_W = MASK_W + TAG_W + CNT_W;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [TAG_W-1:0]  tag;
    logic [CNT_W-1:0]  cnt;
  } tdc_word_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ACTIVE,
    ST_DONE
  } win_state_e;
endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tdc_edge_sampler.sv
module tdc_edge_sampler #(
  parameter int W    = 1,
  parameter bit DUAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] merged;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  if (DUAL) begin : g_dual
    logic [W-1:0] pos_q, neg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pos_q <= '0;
      else         pos_q <= d_i;
    end

    // falling-edge capture catches pulses narrower than one period
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) neg_q <= '0;
      else         neg_q <= d_i;
    end

    assign merged = pos_q | neg_q;
  end else begin : g_single
    assign merged = d_i;
  end

  tdc_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (merged),
    .q_o    (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_q;
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/tdc_window_ctrl.sv
module tdc_window_ctrl
  import tdc_pkg::*;
#(
  parameter int ITER_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [CNT_W-1:0]  cfg_max_i,
  input  logic [ITER_W-1:0] cfg_iter_i,
  input  logic              trig_rise_i,
  input  logic              hit_i,
  output logic              rec_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o,
  output logic              clr_o
);
  win_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q, max_q;
  logic [ITER_W-1:0] left_q;
  logic              arm_ok;
  logic              last_tick;

  assign arm_ok    = (state_q == ST_IDLE) && arm_i;
  assign last_tick = (state_q == ST_ACTIVE) && (cnt_q == max_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      max_q   <= '0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arm_i) begin
          max_q   <= cfg_max_i;
          left_q  <= cfg_iter_i;
          state_q <= (cfg_iter_i == '0) ? ST_DONE : ST_ARMED;
        end
        ST_ARMED: if (trig_rise_i) begin
          cnt_q   <= '0;
          state_q <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_tick) begin
            left_q  <= left_q - 1'b1;
            state_q <= (left_q == ITER_W'(1)) ? ST_DONE : ST_ARMED;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rec_o  = (state_q == ST_ACTIVE) && hit_i;
  assign cnt_o  = cnt_q;
  assign done_o = (state_q == ST_DONE);
  assign clr_o  = arm_ok;
endmodule

// File: rtl/tdc_out_hold.sv
module tdc_out_hold #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] word_i,
  input  logic         clr_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         ovf_o
);
  logic         vld_q, ovf_q;
  logic [W-1:0] data_q;
  logic         room;

  assign room = !vld_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (push_i && room) begin
      vld_q  <= 1'b1;
      data_q <= word_i;
    end else if (vld_q && ready_i) begin
      vld_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ovf_q <= 1'b0;
    else if (clr_i)         ovf_q <= 1'b0;
    else if (push_i && !room) ovf_q <= 1'b1;
  end

  assign valid_o = vld_q;
  assign data_o  = data_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/pulse_tdc.sv
module pulse_tdc
  import tdc_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int ITER_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [CNT_W-1:0]  cfg_max_i,
  input  logic [ITER_W-1:0] cfg_iter_i,
  input  logic              trig_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [N_CH-1:0]   pulse_i,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic [WORD_W-1:0] m_tdata_o,
  output logic              done_o,
  output logic              overflow_o
);
  logic [N_CH-1:0]   ch_rise;
  logic              trig_rise;
  logic [TAG_W-1:0]  tag_s;
  logic              rec;
  logic              clr;
  logic [CNT_W-1:0]  cnt;
  logic [MASK_W-1:0] mask_ext;
  tdc_word_t         word;

  tdc_edge_sampler #(.W(N_CH), .DUAL(1'b1)) u_ch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pulse_i),
    .rise_o (ch_rise)
  );

  // same path as the channels so relative timing is preserved
  tdc_edge_sampler #(.W(1), .DUAL(1'b1)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (trig_i),
    .rise_o (trig_rise)
  );

  tdc_sync #(.W(TAG_W), .STAGES(2)) u_tag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tag_i),
    .q_o    (tag_s)
  );

  tdc_window_ctrl #(.ITER_W(ITER_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .cfg_max_i   (cfg_max_i),
    .cfg_iter_i  (cfg_iter_i),
    .trig_rise_i (trig_rise),
    .hit_i       (|ch_rise),
    .rec_o       (rec),
    .cnt_o       (cnt),
    .done_o      (done_o),
    .clr_o       (clr)
  );

  always_comb begin
    mask_ext             = '0;
    mask_ext[N_CH-1:0]   = ch_rise;
    word.mask            = mask_ext;
    word.tag             = tag_s;
    word.cnt             = cnt;
  end

  tdc_out_hold #(.W(WORD_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rec),
    .word_i  (word),
    .clr_i   (clr),
    .ready_i (m_tready_i),
    .valid_o (m_tvalid_o),
    .data_o  (m_tdata_o),
    .ovf_o   (overflow_o)
  );
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int N_CH = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        arm_i,
  input logic        m_tvalid_o,
  input logic        m_tready_i,
  input logic [63:0] m_tdata_o,
  input logic        done_o,
  input logic        overflow_o
);
  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !arm_i |=> overflow_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  mask_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o |-> (m_tdata_o[63:32] != 32'd0));

  if (N_CH < 32) begin : g_pad
    // R4
    mask_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_tvalid_o |-> (m_tdata_o[63:32+N_CH] == '0));
  end
endmodule

bind pulse_tdc tdc_checker #(.N_CH(N_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .m_tvalid_o (m_tvalid_o),
  .m_tready_i (m_tready_i),
  .m_tdata_o  (m_tdata_o),
  .done_o     (done_o),
  .overflow_o (overflow_o)
);

// File: tb/tb_pulse_tdc.sv
`timescale 1ns/1ps
module tb_pulse_tdc;
  localparam int N_CH   = 8;
  localparam int ITER_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              arm_i = 1'b0;
  logic [23:0]       cfg_max_i = '0;
  logic [ITER_W-1:0] cfg_iter_i = '0;
  logic              trig_i = 1'b0;
  logic [7:0]        tag_i = '0;
  logic [N_CH-1:0]   pulse_i = '0;
  logic              m_tvalid_o;
  logic              m_tready_i = 1'b1;
  logic [63:0]       m_tdata_o;
  logic              done_o;
  logic              overflow_o;

  pulse_tdc #(.N_CH(N_CH), .ITER_W(ITER_W)) dut (.*);

  always #5 clk_i = ~clk_i;

  int          tick = 0;
  int          t0 = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  int          done_cnt = 0;
  bit          finished = 1'b0;
  logic [63:0] exp_q [$];

  always @(posedge clk_i) tick <= tick + 1;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) done_cnt++;
    if (rst_ni && m_tvalid_o && m_tready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected record", m_tdata_o, 64'h0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(m_tdata_o == e, "R2/R3/R4", "record", m_tdata_o, e);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic arm(logic [23:0] mx, logic [ITER_W-1:0] it);
    step(1);
    cfg_max_i = mx; cfg_iter_i = it; arm_i = 1'b1;
    step(1);
    arm_i = 1'b0;
  endtask

  task automatic fire_trig(logic [N_CH-1:0] also);
    step(1);
    t0 = tick;
    trig_i = 1'b1; pulse_i = also;
    #5;
    trig_i = 1'b0; pulse_i = '0;
  endtask

  task automatic wait_rel(int rel);
    while (tick < t0 + rel) begin
      @(posedge clk_i);
      #2;
    end
  endtask

  // 5 ns pulse between rising edges; expected record pushed if exp
  task automatic hit(int rel, logic [N_CH-1:0] m, bit exp);
    wait_rel(rel);
    pulse_i = m;
    #5;
    pulse_i = '0;
    if (exp) exp_q.push_back({24'(0), m, tag_i, 24'(rel - 1)});
  endtask

  task automatic retrig(int rel);
    wait_rel(rel);
    trig_i = 1'b1;
    #5;
    trig_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    // R12 reset state
    chk(m_tvalid_o == 1'b0, "R12", "valid after reset", 64'(m_tvalid_o), 64'h0);
    chk(done_o == 1'b0, "R12", "done after reset", 64'(done_o), 64'h0);
    chk(overflow_o == 1'b0, "R12", "overflow after reset", 64'(overflow_o), 64'h0);
    rst_ni = 1'b1;
    step(3);

    // single window: R1 narrow pulses, R2 count, R3 tag, R4 merge, R13 spacing
    tag_i = 8'hA5;
    step(4);
    arm(24'd20, 16'd1);
    fire_trig('0);
    hit(3, 8'h01, 1'b1);
    hit(5, 8'h06, 1'b1);
    hit(6, 8'h80, 1'b1);
    hit(10, 8'h10, 1'b1);
    hit(12, 8'h10, 1'b1);
    step(40);
    chk(done_cnt == 1, "R8", "done after single window", 64'(done_cnt), 64'd1);
    chk(exp_q.size() == 0, "R13", "records drained", 64'(exp_q.size()), 64'd0);

    // R9 trigger after done is ignored
    fire_trig('0);
    hit(2, 8'h01, 1'b0);
    step(20);
    chk(m_tvalid_o == 1'b0, "R9", "no record when done", 64'(m_tvalid_o), 64'h0);

    // two windows: R2 same tick, R7 retrigger, R6 boundary, R8 count
    tag_i = 8'h3C;
    step(4);
    arm(24'd5, 16'd2);
    fire_trig(8'h02);
    hit(4, 8'h02, 1'b1);
    retrig(5);
    hit(6, 8'h04, 1'b1);
    hit(7, 8'h08, 1'b0);
    step(12);
    chk(done_cnt == 1, "R8", "no done after first of two", 64'(done_cnt), 64'd1);
    chk(exp_q.size() == 0, "R6", "window A drained", 64'(exp_q.size()), 64'd0);
    fire_trig('0);
    hit(1, 8'h20, 1'b1);
    hit(3, 8'h40, 1'b1);
    step(20);
    chk(done_cnt == 2, "R8", "done after second window", 64'(done_cnt), 64'd2);

    // R8 zero windows
    arm(24'd3, 16'd0);
    step(5);
    chk(done_cnt == 3, "R8", "done with zero windows", 64'(done_cnt), 64'd3);
    chk(m_tvalid_o == 1'b0, "R5", "no record zero windows", 64'(m_tvalid_o), 64'h0);

    // R10/R11 back-pressure
    tag_i = 8'h11;
    m_tready_i = 1'b0;
    step(4);
    arm(24'd10, 16'd1);
    fire_trig('0);
    hit(2, 8'h01, 1'b1);
    hit(4, 8'h02, 1'b0);
    step(20);
    chk(overflow_o == 1'b1, "R11", "overflow set", 64'(overflow_o), 64'h1);
    chk(m_tvalid_o == 1'b1, "R10", "valid held", 64'(m_tvalid_o), 64'h1);
    chk(m_tdata_o == exp_q[0], "R10", "held record", m_tdata_o, exp_q[0]);
    m_tready_i = 1'b1;
    step(5);
    chk(overflow_o == 1'b1, "R11", "overflow sticky", 64'(overflow_o), 64'h1);
    chk(exp_q.size() == 0, "R10", "held record delivered", 64'(exp_q.size()), 64'd0);
    arm(24'd2, 16'd0);
    chk(overflow_o == 1'b0, "R11", "overflow cleared by arm", 64'(overflow_o), 64'h0);
    step(5);
    chk(done_cnt == 5, "R8", "total done pulses", 64'(done_cnt), 64'd5);
    chk(exp_q.size() == 0, "R5", "final queue", 64'(exp_q.size()), 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule